// File: doc/BRIEF.md
# Frame-Word Pixel Unpacker with Colour Palette

This block sits between a frame-buffer fetch path and a display pipeline. It receives 32-bit words from the frame buffer over a valid/ready stream and emits one 24-bit colour pixel per output handshake. A word can hold thirty-two 1-bit pixels, sixteen 2-bit pixels, eight 4-bit pixels, four 8-bit pixels, two 16-bit pixels or a single 24-bit pixel. A dense 24-bit mode packs four pixels into every three words. Configuration inputs choose the depth, the byte and pixel ordering, and the 16-bit colour layout. They are expected to stay stable while a stream is in flight.

Pixels of 8 bits or fewer are treated as indices into a 256-entry colour table. Software loads that table through a simple write port. 16-bit pixels are widened to 8 bits per component by repeating their top bits. 24-bit pixels pass through unchanged. Every output pixel has red in bits 7:0, green in bits 15:8 and blue in bits 23:16. The output register is shared by the table-read path and the direct path, so all depths have the same latency. When the consumer is slow, the block holds its output and stops taking input.

Top module: `pix_unpacker`

## Requirements
- R1: `cfg_depth` selects the pixel width: 0 is 1 bit, 1 is 2 bits, 2 is 4 bits, 3 is 8 bits, 4 is 16 bits and 5 is 24 bits. Codes 6 and 7 behave as 5. Each word yields exactly 32/width pixels, or one pixel at 24 bits when `cfg_dense24` is 0. No further pixel follows.
- R2: At depth codes 0 to 3, the pixel value is an index into the colour table, and the output is the stored entry. An entry and `out_pixel` both hold red in bits 7:0, green in bits 15:8 and blue in bits 23:16.
- R3: At depth code 4, the 16-bit value has fields F2 in bits 15:11, F1 in bits 10:5 and F0 in bits 4:0. With `cfg_rgb565`=1, F2 is red and F0 is blue. With `cfg_rgb565`=0, F2 is blue and F0 is red. Each field is widened to 8 bits by copying its most significant bits into the vacated low bits.
- R4: With `cfg_order`=0, pixel k of a word is taken from bits [k*w +: w], where w is the pixel width.
- R5: With `cfg_order`=1, pixel k of a word is taken from bits [32-(k+1)*w +: w].
- R6: With `cfg_order`=2 and w below 8, the bytes are used from byte 0 upward, and pixels inside each byte run from its most significant end. With w of 8 or more, code 2 acts as code 0. Code 3 acts as code 0.
- R7: At 24 bits with `cfg_dense24`=0, the pixel is word bits 23:0. With `cfg_order`=1 it is bits 31:8.
- R8: At 24 bits with `cfg_dense24`=1, the words form a byte stream, and three words yield exactly four pixels. With `cfg_order`=0 or 2, the stream runs byte 0 first, and the first byte of a pixel is red. With `cfg_order`=1, the stream runs byte 3 first, and the first byte of a pixel is blue.
- R9: A colour-table write is seen by every lookup issued in a later cycle.
- R10: With `out_ready` high and the block idle, the first pixel of an accepted word is valid at the port two clock edges after the accepting edge. The valid flag matches the data for table and direct pixels alike.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_pixel` hold their values. No pixel is lost or repeated across any stall pattern.
- R12: During and after reset, `out_valid` is 0 and `in_ready` is 1. Reset in mid-stream discards all pending pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_depth | input | 3 | Pixel depth code |
| cfg_order | input | 2 | Byte and pixel ordering code |
| cfg_rgb565 | input | 1 | 16-bit layout select, 1 = red in top field |
| cfg_dense24 | input | 1 | Dense 24-bit packing enable |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_word | input | 32 | Frame-buffer word |
| pal_we | input | 1 | Colour-table write enable |
| pal_addr | input | 8 | Colour-table write index |
| pal_data | input | 24 | Colour-table write data |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer ready for a pixel |
| out_pixel | output | 24 | Pixel: red 7:0, green 15:8, blue 23:16 |

## Verification
The bench builds the block with its default parameters: 32-bit words, 24-bit pixels, a 256-entry table and the dense path generated in. These values let it reach every depth code, including the aliased codes 6 and 7, as well as the full 8-bit index range of the table and the three-words-to-four-pixels dense packing. Each table entry is given a distinct value derived from its index, so any wrong slice position or ordering shows up as a wrong colour. A repeating stall pattern on `out_ready` exercises the hold and no-loss behaviour on both the word slicer and the dense packer.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

   typedef enum logic [1:0] {
      ORD_LL  = 2'd0,
      ORD_BB  = 2'd1,
      ORD_LB  = 2'd2,
      ORD_RSV = 2'd3
   } pxu_order_e;

   // Depth codes above the 24-bit code alias onto it.
   function automatic logic [2:0] pxu_depth_norm(input logic [2:0] code);
      return (code > 3'd5) ? 3'd5 : code;
   endfunction

   function automatic pxu_order_e pxu_order_norm(input logic [1:0] code);
      return (code == 2'd3) ? ORD_LL : pxu_order_e'(code);
   endfunction

   function automatic logic [4:0] pxu_bpp(input logic [2:0] d);
      case (d)
         3'd0:    return 5'd1;
         3'd1:    return 5'd2;
         3'd2:    return 5'd4;
         3'd3:    return 5'd8;
         3'd4:    return 5'd16;
         default: return 5'd24;
      endcase
   endfunction

   // Index of the last pixel inside one 32-bit word.
   function automatic logic [4:0] pxu_last_idx(input logic [2:0] d);
      return (d <= 3'd4) ? (5'd31 >> d) : 5'd0;
   endfunction

   // 16-bit to 24-bit widening with top-bit replication.
   function automatic logic [23:0] pxu_expand16(input logic [15:0] v, input logic rgb);
      logic [7:0] hi8, mid8, lo8;
      hi8  = {v[15:11], v[15:13]};
      mid8 = {v[10:5],  v[10:9]};
      lo8  = {v[4:0],   v[4:2]};
      return rgb ? {lo8, mid8, hi8} : {hi8, mid8, lo8};
   endfunction

endpackage

// File: rtl/pxu_word_slicer.sv
module pxu_word_slicer
   import pxu_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int PIX_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        depth,
   input  pxu_order_e        order,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   output logic              in_ready,
   output logic              px_valid,
   output logic [PIX_W-1:0]  px_raw,
   input  logic              take
);
   localparam int IDX_W = $clog2(WORD_W);
   localparam int POS_W = IDX_W + 1;

   logic [WORD_W-1:0] cur_q;
   logic              cur_vld_q;
   logic [IDX_W-1:0]  idx_q;

   logic [4:0]        bpp;
   logic [IDX_W-1:0]  last_idx;
   logic [POS_W-1:0]  lin;
   logic [POS_W-1:0]  pos;
   logic [PIX_W-1:0]  mask;
   logic              last;

   always_comb begin
      bpp      = pxu_bpp(depth);
      last_idx = IDX_W'(pxu_last_idx(depth));
      lin      = POS_W'(idx_q) << depth;
      case (order)
         ORD_BB:  pos = POS_W'(WORD_W) - POS_W'(bpp) - lin;
         ORD_LB: begin
            if (bpp < 5'd8)
               pos = {lin[POS_W-1:3], 3'b000} + POS_W'(8) - POS_W'(bpp)
                     - {{(POS_W-3){1'b0}}, lin[2:0]};
            else
               pos = lin;
         end
         default: pos = lin;
      endcase
      if (bpp >= 5'(PIX_W)) mask = '1;
      else                  mask = (PIX_W'(1) << bpp) - PIX_W'(1);
      px_raw   = PIX_W'(cur_q >> pos) & mask;
      last     = (idx_q == last_idx);
      px_valid = cur_vld_q;
      in_ready = !cur_vld_q || (take && last);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q     <= '0;
         cur_vld_q <= 1'b0;
         idx_q     <= '0;
      end else if (in_valid && in_ready) begin
         cur_q     <= in_word;
         cur_vld_q <= 1'b1;
         idx_q     <= '0;
      end else if (take) begin
         if (last) cur_vld_q <= 1'b0;
         else      idx_q     <= idx_q + IDX_W'(1);
      end
   end

endmodule

// File: rtl/pxu_dense_packer.sv
module pxu_dense_packer #(
   parameter int WORD_W = 32,
   parameter int PIX_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              big,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   output logic              in_ready,
   output logic              px_valid,
   output logic [PIX_W-1:0]  px_raw,
   input  logic              take
);
   localparam int NBYTE = WORD_W / 8;
   localparam int PIX_B = PIX_W / 8;
   localparam int HOLD_W = 2 * WORD_W;
   localparam int CNT_W = $clog2(2 * NBYTE + 1);

   logic [HOLD_W-1:0] hold_q, hold_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic [WORD_W-1:0] stream_w;

   always_comb begin
      for (int i = 0; i < NBYTE; i++)
         stream_w[8*i +: 8] = big ? in_word[WORD_W-8-8*i +: 8] : in_word[8*i +: 8];
      for (int i = 0; i < PIX_B; i++)
         px_raw[8*i +: 8] = big ? hold_q[8*(PIX_B-1-i) +: 8] : hold_q[8*i +: 8];
      in_ready = (cnt_q <= CNT_W'(NBYTE));
      px_valid = (cnt_q >= CNT_W'(PIX_B));
   end

   always_comb begin
      hold_d = hold_q;
      cnt_d  = cnt_q;
      if (take) begin
         hold_d = hold_q >> PIX_W;
         cnt_d  = cnt_q - CNT_W'(PIX_B);
      end
      if (in_valid && in_ready) begin
         hold_d = hold_d | ({{WORD_W{1'b0}}, stream_w} << {cnt_d, 3'b000});
         cnt_d  = cnt_d + CNT_W'(NBYTE);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         cnt_q  <= '0;
      end else begin
         hold_q <= hold_d;
         cnt_q  <= cnt_d;
      end
   end

endmodule

// File: rtl/pxu_palette.sv
module pxu_palette #(
   parameter int ENTRIES = 256,
   parameter int PIX_W   = 24
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [$clog2(ENTRIES)-1:0] waddr,
   input  logic [PIX_W-1:0]           wdata,
   input  logic                       re,
   input  logic [$clog2(ENTRIES)-1:0] raddr,
   output logic [PIX_W-1:0]           rdata
);
   logic [PIX_W-1:0] mem [ENTRIES];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= mem[raddr];
   end

endmodule

// File: rtl/pxu_format.sv
module pxu_format
   import pxu_pkg::*;
#(
   parameter int PIX_W  = 24,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        depth,
   input  logic              rgb565,
   input  logic              sl_valid,
   input  logic [PIX_W-1:0]  sl_raw,
   input  logic              out_ready,
   output logic              sl_take,
   output logic              pal_re,
   output logic [ADDR_W-1:0] pal_raddr,
   input  logic [PIX_W-1:0]  pal_rdata,
   output logic              out_valid,
   output logic [PIX_W-1:0]  out_pixel
);
   logic             vld_q;
   logic             use_pal_q;
   logic [PIX_W-1:0] direct_q;
   logic             advance;
   logic             indexed;

   always_comb begin
      advance   = !vld_q || out_ready;
      indexed   = (depth <= 3'd3);
      sl_take   = sl_valid && advance;
      pal_re    = sl_take && indexed;
      pal_raddr = sl_raw[ADDR_W-1:0];
      out_valid = vld_q;
      out_pixel = use_pal_q ? pal_rdata : direct_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q     <= 1'b0;
         use_pal_q <= 1'b0;
         direct_q  <= '0;
      end else if (advance) begin
         vld_q <= sl_valid;
         if (sl_valid) begin
            use_pal_q <= indexed;
            direct_q  <= (depth == 3'd4) ? pxu_expand16(sl_raw[15:0], rgb565) : sl_raw;
         end
      end
   end

endmodule

// File: rtl/pix_unpacker.sv
module pix_unpacker
   import pxu_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int PIX_W       = 24,
   parameter int PAL_ENTRIES = 256,
   parameter bit DENSE_EN    = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [2:0]                     cfg_depth,
   input  logic [1:0]                     cfg_order,
   input  logic                           cfg_rgb565,
   input  logic                           cfg_dense24,
   input  logic                           in_valid,
   output logic                           in_ready,
   input  logic [WORD_W-1:0]              in_word,
   input  logic                           pal_we,
   input  logic [$clog2(PAL_ENTRIES)-1:0] pal_addr,
   input  logic [PIX_W-1:0]               pal_data,
   output logic                           out_valid,
   input  logic                           out_ready,
   output logic [PIX_W-1:0]               out_pixel
);
   localparam int PAL_AW = $clog2(PAL_ENTRIES);

   if (WORD_W != 32) begin : g_bad_word
      $error("pix_unpacker: WORD_W must be 32");
   end
   if (PIX_W != 24) begin : g_bad_pix
      $error("pix_unpacker: PIX_W must be 24");
   end
   if (PAL_ENTRIES != 256) begin : g_bad_pal
      $error("pix_unpacker: PAL_ENTRIES must be 256 for 8-bit indices");
   end

   logic [2:0]       depth_n;
   pxu_order_e       order_n;
   logic             dense_sel;

   logic             w_ready, w_valid, d_ready, d_valid;
   logic [PIX_W-1:0] w_raw, d_raw;
   logic             sl_valid, sl_take;
   logic [PIX_W-1:0] sl_raw;
   logic             pal_re;
   logic [PAL_AW-1:0] pal_raddr;
   logic [PIX_W-1:0] pal_rdata;

   always_comb begin
      depth_n   = pxu_depth_norm(cfg_depth);
      order_n   = pxu_order_norm(cfg_order);
      dense_sel = DENSE_EN && (depth_n == 3'd5) && cfg_dense24;
      sl_valid  = dense_sel ? d_valid : w_valid;
      sl_raw    = dense_sel ? d_raw   : w_raw;
      in_ready  = dense_sel ? d_ready : w_ready;
   end

   pxu_word_slicer #(.WORD_W(WORD_W), .PIX_W(PIX_W)) u_slicer (
      .clk      (clk),
      .rst_n    (rst_n),
      .depth    (depth_n),
      .order    (order_n),
      .in_valid (in_valid && !dense_sel),
      .in_word  (in_word),
      .in_ready (w_ready),
      .px_valid (w_valid),
      .px_raw   (w_raw),
      .take     (sl_take && !dense_sel)
   );

   if (DENSE_EN) begin : g_dense
      pxu_dense_packer #(.WORD_W(WORD_W), .PIX_W(PIX_W)) u_dense (
         .clk      (clk),
         .rst_n    (rst_n),
         .big      (order_n == ORD_BB),
         .in_valid (in_valid && dense_sel),
         .in_word  (in_word),
         .in_ready (d_ready),
         .px_valid (d_valid),
         .px_raw   (d_raw),
         .take     (sl_take && dense_sel)
      );
   end else begin : g_no_dense
      assign d_ready = 1'b0;
      assign d_valid = 1'b0;
      assign d_raw   = '0;
   end

   pxu_format #(.PIX_W(PIX_W), .ADDR_W(PAL_AW)) u_format (
      .clk       (clk),
      .rst_n     (rst_n),
      .depth     (depth_n),
      .rgb565    (cfg_rgb565),
      .sl_valid  (sl_valid),
      .sl_raw    (sl_raw),
      .out_ready (out_ready),
      .sl_take   (sl_take),
      .pal_re    (pal_re),
      .pal_raddr (pal_raddr),
      .pal_rdata (pal_rdata),
      .out_valid (out_valid),
      .out_pixel (out_pixel)
   );

   pxu_palette #(.ENTRIES(PAL_ENTRIES), .PIX_W(PIX_W)) u_palette (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (pal_we),
      .waddr (pal_addr),
      .wdata (pal_data),
      .re    (pal_re),
      .raddr (pal_raddr),
      .rdata (pal_rdata)
   );

endmodule

// File: rtl/pxu_checker.sv
module pxu_checker #(
   parameter int PIX_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             out_valid,
   input logic             out_ready,
   input logic [PIX_W-1:0] out_pixel,
   input logic             sl_valid,
   input logic             in_ready
);
   // R11: a stalled pixel stays presented
   a_r11_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid);

   // R11: a stalled pixel keeps its value
   a_r11_hold_pixel: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> $stable(out_pixel));

   // R10: output valid only rises after the slicer offered a pixel
   a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(sl_valid));

   // R12: handshake outputs never unknown out of reset
   a_r12_known: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown({out_valid, in_ready}));

   // R11: a dropped output valid means the pixel was taken
   a_r11_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> $past(out_ready));

endmodule

bind pix_unpacker pxu_checker #(.PIX_W(PIX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_pixel (out_pixel),
   .sl_valid  (sl_valid),
   .in_ready  (in_ready)
);

// File: tb/sim_pix_unpacker.sv
`timescale 1ns/1ps
module sim_pix_unpacker;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  cfg_depth;
   logic [1:0]  cfg_order;
   logic        cfg_rgb565, cfg_dense24;
   logic        in_valid, in_ready;
   logic [31:0] in_word;
   logic        pal_we;
   logic [7:0]  pal_addr;
   logic [23:0] pal_data;
   logic        out_valid, out_ready;
   logic [23:0] out_pixel;

   always #10 clk = ~clk;

   pix_unpacker u0 (
      .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_order(cfg_order),
      .cfg_rgb565(cfg_rgb565), .cfg_dense24(cfg_dense24),
      .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
      .pal_we(pal_we), .pal_addr(pal_addr), .pal_data(pal_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit stall_pat = 1'b0;
   logic [31:0] wbuf [8];
   logic [23:0] gbuf [64];
   int ngot;

   always @(posedge clk) cyc <= cyc + 1;

   localparam logic [31:0] W0 = 32'h1234_A5C3;
   // {depth, order, rgb565, k, req, word, expected}
   localparam int NVEC = 21;
   localparam logic [70:0] VEC [NVEC] = '{
      {3'd0, 2'd0, 1'b0, 5'd0, 4'd4,  W0, 24'hFE0201},            // R4
      {3'd0, 2'd0, 1'b0, 5'd2, 4'd1,  W0, 24'hFF0100},            // R1
      {3'd0, 2'd1, 1'b0, 5'd3, 4'd5,  W0, 24'hFE0201},            // R5
      {3'd0, 2'd2, 1'b0, 5'd0, 4'd6,  W0, 24'hFE0201},            // R6
      {3'd0, 2'd2, 1'b0, 5'd2, 4'd6,  W0, 24'hFF0100},            // R6
      {3'd1, 2'd0, 1'b0, 5'd1, 4'd1,  W0, 24'hFF0100},            // R1
      {3'd1, 2'd2, 1'b0, 5'd5, 4'd6,  W0, 24'hFD0302},            // R6
      {3'd2, 2'd0, 1'b0, 5'd3, 4'd2,  W0, 24'hF50B0A},            // R2
      {3'd2, 2'd1, 1'b0, 5'd7, 4'd5,  W0, 24'hFC0403},            // R5
      {3'd2, 2'd2, 1'b0, 5'd0, 4'd6,  W0, 24'hF30D0C},            // R6
      {3'd3, 2'd0, 1'b0, 5'd2, 4'd2,  W0, 24'hCB3534},            // R2
      {3'd3, 2'd1, 1'b0, 5'd0, 4'd5,  W0, 24'hED1312},            // R5
      {3'd3, 2'd3, 1'b0, 5'd1, 4'd6,  W0, 24'h5AA6A5},            // R6
      {3'd4, 2'd0, 1'b1, 5'd0, 4'd3,  W0, 24'h18BAA5},            // R3
      {3'd4, 2'd0, 1'b0, 5'd0, 4'd3,  W0, 24'hA5BA18},            // R3
      {3'd4, 2'd1, 1'b1, 5'd0, 4'd5,  W0, 24'hA54510},            // R5
      {3'd4, 2'd0, 1'b1, 5'd0, 4'd3,  32'hFFFF_0000, 24'h000000}, // R3
      {3'd4, 2'd0, 1'b1, 5'd1, 4'd3,  32'hFFFF_0000, 24'hFFFFFF}, // R3
      {3'd5, 2'd0, 1'b0, 5'd0, 4'd7,  W0, 24'h34A5C3},            // R7
      {3'd5, 2'd1, 1'b0, 5'd0, 4'd7,  W0, 24'h1234A5},            // R7
      {3'd7, 2'd0, 1'b0, 5'd0, 4'd1,  W0, 24'h34A5C3}             // R1
   };

   function automatic logic [23:0] pal_val(input int i);
      logic [7:0] b;
      b = i[7:0];
      return {~b, b + 8'd1, b};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic send_words(input int n);
      int guard;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_word  = wbuf[i];
         #5;
         guard = 0;
         while (!in_ready && guard < 2000) begin
            @(negedge clk);
            #5;
            guard++;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic collect(input int n);
      int guard;
      ngot = 0;
      guard = 0;
      while (ngot < n && guard < 3000) begin
         @(negedge clk);
         out_ready = stall_pat ? (cyc % 3 != 0) : 1'b1;
         #5;
         if (out_valid && out_ready) begin
            gbuf[ngot] = out_pixel;
            ngot++;
         end
         guard++;
      end
      @(negedge clk);
      out_ready = 1'b1;
   endtask

   task automatic run(input int nw, input int np);
      fork
         send_words(nw);
         collect(np);
      join
   endtask

   task automatic expect_idle(input string tag);
      logic seen;
      seen = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         #5;
         if (out_valid) seen = 1'b1;
      end
      chk(tag, {31'd0, seen}, 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      cfg_depth = 3'd3; cfg_order = 2'd0; cfg_rgb565 = 1'b0; cfg_dense24 = 1'b0;
      in_valid = 1'b0; in_word = '0; pal_we = 1'b0; pal_addr = '0; pal_data = '0;
      out_ready = 1'b1;
      repeat (3) @(negedge clk);
      #5;
      chk("R12 out_valid in reset", {31'd0, out_valid}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #5;
      chk("R12 in_ready after reset", {31'd0, in_ready}, 32'd1);
      chk("R12 out_valid after reset", {31'd0, out_valid}, 32'd0);

      // load the colour table with index-derived entries
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         pal_we = 1'b1; pal_addr = 8'(i); pal_data = pal_val(i);
      end
      @(negedge clk);
      pal_we = 1'b0;

      // vector table walk
      for (int v = 0; v < NVEC; v++) begin
         logic [2:0] d;
         logic [4:0] k;
         int ppw;
         d = VEC[v][70:68];
         k = VEC[v][64:60];
         cfg_depth  = d;
         cfg_order  = VEC[v][67:66];
         cfg_rgb565 = VEC[v][65];
         wbuf[0]    = VEC[v][55:24];
         ppw = (d <= 3'd4) ? (32 >> d) : 1;
         run(1, ppw);
         chk($sformatf("R%0d vector %0d count", VEC[v][59:56], v), ngot, ppw);
         chk($sformatf("R%0d vector %0d pixel", VEC[v][59:56], v),
             {8'd0, gbuf[k]}, {8'd0, VEC[v][23:0]});
         expect_idle("R1 no extra pixel after word");
      end

      // dense 24-bit, little ordering
      cfg_depth = 3'd5; cfg_dense24 = 1'b1; cfg_order = 2'd0;
      wbuf[0] = 32'h0302_0100; wbuf[1] = 32'h0706_0504; wbuf[2] = 32'h0B0A_0908;
      run(3, 4);
      chk("R8 dense pixel 0", {8'd0, gbuf[0]}, 32'h0002_0100);
      chk("R8 dense pixel 1", {8'd0, gbuf[1]}, 32'h0005_0403);
      chk("R8 dense pixel 2", {8'd0, gbuf[2]}, 32'h0008_0706);
      chk("R8 dense pixel 3", {8'd0, gbuf[3]}, 32'h000B_0A09);
      expect_idle("R8 three words give four pixels");

      // dense 24-bit, big ordering, with stalls
      cfg_order = 2'd1; stall_pat = 1'b1;
      wbuf[0] = 32'h0001_0203; wbuf[1] = 32'h0405_0607; wbuf[2] = 32'h0809_0A0B;
      run(3, 4);
      chk("R8 dense big pixel 0", {8'd0, gbuf[0]}, 32'h0000_0102);
      chk("R8 dense big pixel 1", {8'd0, gbuf[1]}, 32'h0003_0405);
      chk("R8 dense big pixel 2", {8'd0, gbuf[2]}, 32'h0006_0708);
      chk("R8 dense big pixel 3", {8'd0, gbuf[3]}, 32'h0009_0A0B);

      // stalled 8-bit stream of two words
      cfg_depth = 3'd3; cfg_dense24 = 1'b0; cfg_order = 2'd0;
      wbuf[0] = 32'h0302_0100; wbuf[1] = 32'h0706_0504;
      run(2, 8);
      chk("R11 stalled stream count", ngot, 8);
      for (int i = 0; i < 8; i++)
         chk($sformatf("R11 stalled pixel %0d", i), {8'd0, gbuf[i]}, {8'd0, pal_val(i)});
      stall_pat = 1'b0;
      expect_idle("R11 no duplicate pixel");

      // latency from accepting edge
      @(negedge clk);
      out_ready = 1'b1; in_valid = 1'b1; in_word = W0;
      #5;
      chk("R10 idle block accepts word", {31'd0, in_ready}, 32'd1);
      @(negedge clk);
      in_valid = 1'b0;
      #5;
      chk("R10 not valid after one edge", {31'd0, out_valid}, 32'd0);
      @(negedge clk);
      #5;
      chk("R10 valid after two edges", {31'd0, out_valid}, 32'd1);
      chk("R10 first pixel", {8'd0, out_pixel}, {8'd0, pal_val(8'hC3)});
      repeat (6) @(negedge clk);

      // table rewrite seen by the next lookup
      @(negedge clk);
      pal_we = 1'b1; pal_addr = 8'h34; pal_data = 24'h123456;
      @(negedge clk);
      pal_we = 1'b0;
      wbuf[0] = W0;
      run(1, 4);
      chk("R9 rewritten entry", {8'd0, gbuf[2]}, 32'h0012_3456);
      chk("R9 other entry kept", {8'd0, gbuf[1]}, {8'd0, pal_val(8'hA5)});

      // reset in mid-stream
      cfg_depth = 3'd0;
      @(negedge clk);
      out_ready = 1'b0; in_valid = 1'b1; in_word = W0;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      #5;
      chk("R12 stream pending before reset", {31'd0, out_valid}, 32'd1);
      @(negedge clk);
      rst_n = 1'b0;
      #5;
      chk("R12 reset clears output", {31'd0, out_valid}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      out_ready = 1'b1;
      expect_idle("R12 pending pixels discarded");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule